// File: doc/BRIEF.md
# Configuration Command Decoder with Differential Tone Output

This block sits behind a serial host port in a display controller. Each time the port has collected a complete 9-bit configuration word, it presents the word with a one-cycle valid pulse. The decoder matches the word against a fixed set of command patterns, some of which contain don't-care bits. It then updates a small bank of control registers. These registers enable the system oscillator and bias, enable the display, select the clock source, switch the tone and set its pitch, and choose normal or test mode.

Six of the commands belong to a separate timer and watchdog block. For each of these the decoder emits a single-cycle strobe and keeps no state of its own. The decoder also drives a buzzer. The tone is a complementary pair of outputs derived from the 32 kHz system clock that the block runs on, at either 4 kHz or 2 kHz.

Words are written as bits 8 down to 0 and `x` marks a don't-care bit. Bit 8 is the first bit the host shifts in.

Top module: `cfg_cmd_decoder`

## Requirements
- R1: After reset, all six control outputs are low: oscillator off, display off, internal RC source, tone off, 2 kHz pitch selected, normal mode. All strobes and both tone pins are also low.
- R2: `0000_0001_x` sets `osc_en` and `0000_0000_x` clears it, whatever the value of bit 0.
- R3: `0000_0000_x` leaves `osc_en` unchanged while `clk_ext` is high.
- R4: `0000_0011_x` sets `lcd_en` and `0000_0010_x` clears it.
- R5: `0001_11xx_x` sets `clk_ext` (external source) and `0001_10xx_x` clears it (RC source). Bits 2 to 0 are ignored.
- R6: `010x_xxxx_x` sets `tone_on` and `tone_hi` (4 kHz). `0110_xxxx_x` sets `tone_on` and clears `tone_hi` (2 kHz). `0000_1000_x` clears `tone_on` and keeps `tone_hi`.
- R7: `1110_0000_x` sets `test_mode` and `1110_0011_x` clears it.
- R8: Each of six words raises exactly one strobe for exactly one cycle, the cycle after the word is accepted:
  - `0000_0100_x` raises `tmr_off`.
  - `0000_0101_x` raises `wdt_off`.
  - `0000_0110_x` raises `tmr_on`.
  - `0000_0111_x` raises `wdt_on`.
  - `0000_1101_x` raises `tmr_clr`.
  - `0000_1111_x` raises `wdt_clr`.
- R9: A word that matches no pattern, or any cycle with `cmd_valid` low, changes no control output and raises no strobe.
- R10: While `tone_on` is high, `tone_neg` is the inverse of `tone_pos`. `tone_pos` is low for the first half period after the tone turns on and then toggles every 4 clocks at 4 kHz or every 8 clocks at 2 kHz. While `tone_on` is low, both pins are low.
- R11: A word accepted at a clock edge takes effect on the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle pulse: `cmd_word` holds a complete command |
| cmd_word | input | 9 | Command word, bit 8 first on the wire |
| osc_en | output | 1 | System oscillator and bias enabled |
| lcd_en | output | 1 | Display drive enabled |
| clk_ext | output | 1 | External clock source selected |
| tone_on | output | 1 | Tone output enabled |
| tone_hi | output | 1 | 1 selects 4 kHz, 0 selects 2 kHz |
| test_mode | output | 1 | Test mode active |
| tmr_off | output | 1 | Strobe: disable time base |
| wdt_off | output | 1 | Strobe: disable watchdog flag |
| tmr_on | output | 1 | Strobe: enable time base |
| wdt_on | output | 1 | Strobe: enable watchdog flag |
| tmr_clr | output | 1 | Strobe: clear time base |
| wdt_clr | output | 1 | Strobe: clear watchdog |
| tone_pos | output | 1 | Tone output, true phase |
| tone_neg | output | 1 | Tone output, inverted phase |

## Verification
The hardest case to reach is the ignored system-disable. It only matters once the external source has been selected and the oscillator is already running, so the stimulus first enables the oscillator and then selects the external source. Only then does it send the disable word, and the oscillator enable must stay high. The stimulus then returns to the RC source and repeats the same word to show that it now takes effect.

Tone timing is checked cycle by cycle against the half period expected for each pitch. A tone-off command sits between the two pitch checks so that each one starts from a known phase. The don't-care bits are covered by giving them different values in repeated commands.

// File: rtl/cfgdec_pkg.sv
// Package: shared command operation codes, control register layout and the
// strobe ordering used by the configuration decoder.
package cfgdec_pkg;

    localparam int CMD_W    = 9;
    localparam int NUM_STRB = 6;

    // Decoded operation for one configuration word
    typedef enum logic [4:0] {
        OP_NONE,
        OP_SYS_OFF,
        OP_SYS_ON,
        OP_LCD_OFF,
        OP_LCD_ON,
        OP_TMR_OFF,
        OP_WDT_OFF,
        OP_TMR_ON,
        OP_WDT_ON,
        OP_TONE_OFF,
        OP_TMR_CLR,
        OP_WDT_CLR,
        OP_SRC_RC,
        OP_SRC_EXT,
        OP_TONE_HI,
        OP_TONE_LO,
        OP_TEST,
        OP_NORMAL
    } op_e;

    // Control register bank
    typedef struct packed {
        logic osc_en;
        logic lcd_en;
        logic clk_ext;
        logic tone_on;
        logic tone_hi;
        logic test_mode;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '0;

    // Strobe index order: tmr_off, wdt_off, tmr_on, wdt_on, tmr_clr, wdt_clr
    localparam op_e STRB_OP [NUM_STRB] = '{
        OP_TMR_OFF, OP_WDT_OFF, OP_TMR_ON, OP_WDT_ON, OP_TMR_CLR, OP_WDT_CLR
    };

endpackage

// File: rtl/cfgdec_match.sv
// Module: cfgdec_match
// Purely combinational pattern matcher. Compares a 9-bit configuration word
// with the command patterns, treating don't-care positions as wildcards.
// Assumes: bit 8 is the first bit on the wire; a word that matches no
// pattern maps to OP_NONE.
module cfgdec_match
    import cfgdec_pkg::*;
(
    input  logic [CMD_W-1:0] word,
    output op_e              op
);

    // Wildcard match of the word against every command pattern
    always_comb begin
        casez (word)
            9'b0000_0000_?: op = OP_SYS_OFF;
            9'b0000_0001_?: op = OP_SYS_ON;
            9'b0000_0010_?: op = OP_LCD_OFF;
            9'b0000_0011_?: op = OP_LCD_ON;
            9'b0000_0100_?: op = OP_TMR_OFF;
            9'b0000_0101_?: op = OP_WDT_OFF;
            9'b0000_0110_?: op = OP_TMR_ON;
            9'b0000_0111_?: op = OP_WDT_ON;
            9'b0000_1000_?: op = OP_TONE_OFF;
            9'b0000_1101_?: op = OP_TMR_CLR;
            9'b0000_1111_?: op = OP_WDT_CLR;
            9'b0001_10??_?: op = OP_SRC_RC;
            9'b0001_11??_?: op = OP_SRC_EXT;
            9'b010?_????_?: op = OP_TONE_HI;
            9'b0110_????_?: op = OP_TONE_LO;
            9'b1110_0000_?: op = OP_TEST;
            9'b1110_0011_?: op = OP_NORMAL;
            default:        op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/cfgdec_regs.sv
// Module: cfgdec_regs
// Holds the control register bank and generates one-cycle strobes for the
// timer block. Assumes: op is valid only while cmd_valid is high; the
// system-disable operation is blocked while the external source is selected.
module cfgdec_regs
    import cfgdec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  op_e                 op,
    output ctrl_t               ctrl,
    output logic [NUM_STRB-1:0] strb
);

    // Register bank update on an accepted command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RESET;
        end else if (cmd_valid) begin
            case (op)
                OP_SYS_OFF:  if (!ctrl.clk_ext) ctrl.osc_en <= 1'b0;
                OP_SYS_ON:   ctrl.osc_en    <= 1'b1;
                OP_LCD_OFF:  ctrl.lcd_en    <= 1'b0;
                OP_LCD_ON:   ctrl.lcd_en    <= 1'b1;
                OP_SRC_RC:   ctrl.clk_ext   <= 1'b0;
                OP_SRC_EXT:  ctrl.clk_ext   <= 1'b1;
                OP_TONE_OFF: ctrl.tone_on   <= 1'b0;
                OP_TONE_HI:  begin ctrl.tone_on <= 1'b1; ctrl.tone_hi <= 1'b1; end
                OP_TONE_LO:  begin ctrl.tone_on <= 1'b1; ctrl.tone_hi <= 1'b0; end
                OP_TEST:     ctrl.test_mode <= 1'b1;
                OP_NORMAL:   ctrl.test_mode <= 1'b0;
                default:     ;
            endcase
        end
    end

    // One strobe register per timer-side operation
    for (genvar g = 0; g < NUM_STRB; g++) begin : g_strb
        always_ff @(posedge clk) begin
            if (!rst_n) strb[g] <= 1'b0;
            else        strb[g] <= cmd_valid && (op == STRB_OP[g]);
        end
    end

    AST_SYSOFF_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_SYS_OFF && ctrl.clk_ext) |=> (ctrl.osc_en == $past(ctrl.osc_en))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid) |=> (ctrl == $past(ctrl))); // R9
    AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb)); // R8
    AST_STRB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid) |=> (strb == '0)); // R8

endmodule

// File: rtl/cfgdec_tone.sv
// Module: cfgdec_tone
// Divides the system clock into a complementary tone pair. Assumes: both
// half periods are at least 2 clocks; the phase restarts low whenever the
// tone is off.
module cfgdec_tone #(
    parameter int HALF_HI = 4,
    parameter int HALF_LO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_on,
    input  logic tone_hi,
    output logic tone_pos,
    output logic tone_neg
);

    localparam int MAX_HALF = (HALF_HI > HALF_LO) ? HALF_HI : HALF_LO;
    localparam int CNT_W    = $clog2(MAX_HALF + 1);
    localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(HALF_HI - 1);
    localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(HALF_LO - 1);

    logic [CNT_W-1:0] cnt;
    logic             phase;
    logic [CNT_W-1:0] lim;

    // Terminal count for the selected pitch
    always_comb lim = tone_hi ? LIM_HI : LIM_LO;

    // Half-period counter and phase flip-flop
    always_ff @(posedge clk) begin
        if (!rst_n || !tone_on) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt >= lim) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Gate both pins low while the tone is off
    always_comb begin
        tone_pos = tone_on & phase;
        tone_neg = tone_on & ~phase;
    end

    AST_TONE_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tone_on) |=> !tone_pos); // R10
    AST_TONE_MIN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_on && $past(tone_on) && tone_pos != $past(tone_pos)) |=> (!tone_on || $stable(tone_pos))); // R10

endmodule

// File: rtl/cfg_cmd_decoder.sv
// Module: cfg_cmd_decoder (top)
// Decodes configuration words into control registers and timer strobes and
// drives the differential buzzer tone. Assumes: clk is the 32 kHz system
// clock; cmd_valid is a single-cycle pulse from the serial port.
module cfg_cmd_decoder
    import cfgdec_pkg::*;
#(
    parameter int TONE_HALF_HI = 4,
    parameter int TONE_HALF_LO = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             osc_en,
    output logic             lcd_en,
    output logic             clk_ext,
    output logic             tone_on,
    output logic             tone_hi,
    output logic             test_mode,
    output logic             tmr_off,
    output logic             wdt_off,
    output logic             tmr_on,
    output logic             wdt_on,
    output logic             tmr_clr,
    output logic             wdt_clr,
    output logic             tone_pos,
    output logic             tone_neg
);

    op_e                 op;
    ctrl_t               ctrl;
    logic [NUM_STRB-1:0] strb;

    cfgdec_match u_match (
        .word (cmd_word),
        .op   (op)
    );

    cfgdec_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .op        (op),
        .ctrl      (ctrl),
        .strb      (strb)
    );

    cfgdec_tone #(
        .HALF_HI (TONE_HALF_HI),
        .HALF_LO (TONE_HALF_LO)
    ) u_tone (
        .clk      (clk),
        .rst_n    (rst_n),
        .tone_on  (ctrl.tone_on),
        .tone_hi  (ctrl.tone_hi),
        .tone_pos (tone_pos),
        .tone_neg (tone_neg)
    );

    // Fan the register bank and strobes out to the ports
    always_comb begin
        osc_en    = ctrl.osc_en;
        lcd_en    = ctrl.lcd_en;
        clk_ext   = ctrl.clk_ext;
        tone_on   = ctrl.tone_on;
        tone_hi   = ctrl.tone_hi;
        test_mode = ctrl.test_mode;
        tmr_off   = strb[0];
        wdt_off   = strb[1];
        tmr_on    = strb[2];
        wdt_on    = strb[3];
        tmr_clr   = strb[4];
        wdt_clr   = strb[5];
    end

endmodule

// File: tb/cfg_cmd_decoder_bench.sv
`timescale 1ns/1ps
module cfg_cmd_decoder_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [8:0] cmd_word = '0;
    logic osc_en, lcd_en, clk_ext, tone_on, tone_hi, test_mode;
    logic tmr_off, wdt_off, tmr_on, wdt_on, tmr_clr, wdt_clr;
    logic tone_pos, tone_neg;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    typedef struct {
        logic [5:0] st;   // {osc_en, lcd_en, clk_ext, tone_on, tone_hi, test_mode}
        logic [5:0] sb;   // {tmr_off, wdt_off, tmr_on, wdt_on, tmr_clr, wdt_clr}
        string      req;
    } exp_t;

    exp_t exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_cmd_decoder u_cfg_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .osc_en(osc_en), .lcd_en(lcd_en), .clk_ext(clk_ext), .tone_on(tone_on),
        .tone_hi(tone_hi), .test_mode(test_mode), .tmr_off(tmr_off), .wdt_off(wdt_off),
        .tmr_on(tmr_on), .wdt_on(wdt_on), .tmr_clr(tmr_clr), .wdt_clr(wdt_clr),
        .tone_pos(tone_pos), .tone_neg(tone_neg)
    );

    function automatic logic [5:0] state_now();
        return {osc_en, lcd_en, clk_ext, tone_on, tone_hi, test_mode};
    endfunction

    function automatic logic [5:0] strb_now();
        return {tmr_off, wdt_off, tmr_on, wdt_on, tmr_clr, wdt_clr};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: present one word for one cycle and queue the expected result
    task automatic send(input logic [8:0] w, input logic [5:0] st,
                        input logic [5:0] sb, input string req);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        exp_q.push_back('{st, sb, req});
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Driver: idle cycle with a live-looking word but no valid
    task automatic idle(input logic [8:0] w, input logic [5:0] st, input string req);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = w;
        exp_q.push_back('{st, 6'b0, req});
        @(negedge clk);
    endtask

    // Strobe command followed by a check that the strobe has dropped
    task automatic strobe_cmd(input logic [8:0] w, input logic [5:0] st,
                              input logic [5:0] sb);
        send(w, st, sb, "R8");
        @(negedge clk);
        chk(strb_now() == 6'b0, "R8", "strobe one cycle", 32'(strb_now()), 32'h0);
    endtask

    // Tone phase check from the cycle right after the enabling edge
    task automatic check_tone(input int half, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic ep;
            ep = ((i / half) % 2) == 1;
            chk(tone_pos == ep && tone_neg == !ep, req, "tone pair",
                32'({tone_pos, tone_neg}), 32'({ep, !ep}));
            @(negedge clk);
        end
    endtask

    // Monitor: compare the queued expectation just after each clock edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(state_now() == e.st, e.req, "registers", 32'(state_now()), 32'(e.st));
                chk(strb_now() == e.sb, e.req, "strobes", 32'(strb_now()), 32'(e.sb));
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(state_now() == 6'b0, "R1", "registers", 32'(state_now()), 32'h0);
        chk(strb_now() == 6'b0, "R1", "strobes", 32'(strb_now()), 32'h0);
        chk(tone_pos == 1'b0 && tone_neg == 1'b0, "R1", "tone pins",
            32'({tone_pos, tone_neg}), 32'h0);

        send(9'b0000_0001_1, 6'b100000, 6'b0, "R2");   // R11 visible next cycle
        send(9'b0000_0011_0, 6'b110000, 6'b0, "R4");
        send(9'b0000_0010_1, 6'b100000, 6'b0, "R4");
        send(9'b0000_0011_1, 6'b110000, 6'b0, "R4");

        // R6 and R10: 4 kHz tone
        send(9'b0101_0101_1, 6'b110110, 6'b0, "R6");
        check_tone(4, 16, "R10");
        send(9'b0000_1000_1, 6'b110010, 6'b0, "R6");
        for (int i = 0; i < 4; i++) begin
            chk(tone_pos == 1'b0 && tone_neg == 1'b0, "R10", "tone off pins",
                32'({tone_pos, tone_neg}), 32'h0);
            @(negedge clk);
        end
        // R6 and R10: 2 kHz tone
        send(9'b0110_1010_0, 6'b110100, 6'b0, "R6");
        check_tone(8, 24, "R10");
        send(9'b0100_1110_0, 6'b110110, 6'b0, "R6");
        send(9'b0000_1000_0, 6'b110010, 6'b0, "R6");

        // R5 and R3: source select and blocked system disable
        send(9'b0001_1110_1, 6'b111010, 6'b0, "R5");
        send(9'b0000_0000_1, 6'b111010, 6'b0, "R3");
        send(9'b0001_1001_0, 6'b110010, 6'b0, "R5");
        send(9'b0000_0000_0, 6'b010010, 6'b0, "R2");
        send(9'b0000_0001_0, 6'b110010, 6'b0, "R2");

        // R7 test and normal
        send(9'b1110_0000_1, 6'b110011, 6'b0, "R7");
        send(9'b1110_0011_0, 6'b110010, 6'b0, "R7");

        // R9 unrecognised words
        send(9'b1111_1111_1, 6'b110010, 6'b0, "R9");
        send(9'b1000_1000_0, 6'b110010, 6'b0, "R9");
        send(9'b1010_0001_1, 6'b110010, 6'b0, "R9");
        send(9'b0000_1001_0, 6'b110010, 6'b0, "R9");
        send(9'b1110_0001_0, 6'b110010, 6'b0, "R9");

        // R8 timer strobes
        strobe_cmd(9'b0000_0100_0, 6'b110010, 6'b100000);
        strobe_cmd(9'b0000_0101_1, 6'b110010, 6'b010000);
        strobe_cmd(9'b0000_0110_0, 6'b110010, 6'b001000);
        strobe_cmd(9'b0000_0111_1, 6'b110010, 6'b000100);
        strobe_cmd(9'b0000_1101_0, 6'b110010, 6'b000010);
        strobe_cmd(9'b0000_1111_1, 6'b110010, 6'b000001);

        // R9 words without valid
        idle(9'b0000_0000_0, 6'b110010, "R9");
        idle(9'b0101_0000_0, 6'b110010, "R9");
        idle(9'b0000_0100_0, 6'b110010, "R9");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule